// File: doc/BRIEF.md
# Dual-Bank GPIO Controller with Line Ownership

This peripheral drives and samples a set of general-purpose pins through two parallel register banks. Each bank has its own output, direction, input, trigger-level, flag, mask and input-mirror registers, its own level-sensitive interrupt logic and its own interrupt output. A per-line ownership register decides which bank's output and direction values reach each pin. Each bank only raises flags for the lines it owns.

The open bank can always be reached. The protected bank, together with the ownership register and a general line-enable storage register, answers the bus only while the `perm_i` input is high. Otherwise its reads return zero and its writes are dropped. Pin inputs pass through a synchronizer before they reach the input registers and the flag logic. All registers use a big-endian byte order on the bus.

Top module: `gpio_dual_bank`

## Requirements
- R1: After reset, ownership, output, direction, mask, level and flag registers are zero. So `pin_oe` and `pin_out` are zero and both interrupt outputs are low.
- R2: Register byte lanes are swapped on the bus. Register bits [7:0] travel on bus bits [31:24], [15:8] on [23:16], [23:16] on [15:8], and [31:24] on [7:0]. This holds for both writes and reads.
- R3: Ownership register (offset 0x3C) bit n = 1 routes the open bank's OUT (0x00) and DIR (0x04) bit n to `pin_out[n]` and `pin_oe[n]`. Bit n = 0 routes the protected bank's OUT (0x20) and DIR (0x24) bit n instead.
- R4: While `perm_i` is low, reads of offsets 0x1C to 0x3C return zero and writes to them change nothing. Offsets 0x00 to 0x18 work regardless of `perm_i`.
- R5: IN (0x08 / 0x28) and the input mirror (0x18 / 0x38) read the pin inputs two clock edges after they change.
- R6: A flag bit (0x10 / 0x30) sets while the synchronized input equals the bank's level bit (0x0C / 0x2C; 1 = active high). This applies only to lines the bank owns. Flags of lines the bank does not own read zero.
- R7: Writing 1 to a flag bit clears it at that edge, and writing 0 leaves it alone. If the active level persists, the flag sets again one edge later.
- R8: `irq_open` / `irq_prot` is high exactly when the bank's flag AND mask (0x14 / 0x34) is nonzero.
- R9: Writes to OUT or DIR bits of lines a bank does not own are stored and read back, but they do not change the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| perm_i | input | 1 | Grants access to the protected bank and the ownership register |
| bus_addr | input | 6 | Byte address; bits [5:2] select the register |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data, big-endian lanes |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational, big-endian lanes |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin output enables (1 = drive) |
| irq_open | output | 1 | Open bank interrupt |
| irq_prot | output | 1 | Protected bank interrupt |

## Verification
The bench goes after the permission gate: it writes protected registers with `perm_i` low and then reads them back with permission. A design that leaked those writes would show corrupted protected values or ownership. The bench sets mixed ownership and checks every pin against the bank that owns it, so a swapped mux or a non-owner write reaching a pin shows up as a wrong pin value. It reads a flag in the cycle right after a one-to-clear write and again one cycle later. A design that gave set priority over clear, or that never re-armed the flag, fails one of those two samples. Raw bus values are checked against pin positions, which catches a missing or misordered byte swap.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

   // register slot within a bank, taken from address bits [4:2]
   typedef enum logic [2:0] {
      RS_OUT  = 3'd0,
      RS_DIR  = 3'd1,
      RS_IN   = 3'd2,
      RS_LVL  = 3'd3,
      RS_FLAG = 3'd4,
      RS_MASK = 3'd5,
      RS_MIR  = 3'd6,
      RS_NONE = 3'd7
   } reg_slot_e;

   localparam int unsigned BUS_W = 32;

   function automatic logic [BUS_W-1:0] lane_swap(input logic [BUS_W-1:0] v);
      return {v[7:0], v[15:8], v[23:16], v[31:24]};
   endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   if (STAGES < 1 || STAGES > 4) begin : g_bad_stages
      $error("gpio_sync: STAGES must be 1..4");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[0] <= '0;
            else        stage_q[0] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_pkg::*;
#(
   parameter int unsigned LINES = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] owned_i,
   input  logic [LINES-1:0] sync_i,
   input  logic             wr_en_i,
   input  reg_slot_e        wr_slot_i,
   input  logic [LINES-1:0] wdata_i,
   input  reg_slot_e        rd_slot_i,
   output logic [LINES-1:0] rdata_o,
   output logic [LINES-1:0] out_o,
   output logic [LINES-1:0] dir_o,
   output logic             irq_o
);

   logic [LINES-1:0] out_q, dir_q, lvl_q, mask_q, flag_q;
   logic [LINES-1:0] hit, clr, flag_d;

   assign hit = owned_i & ~(sync_i ^ lvl_q);
   assign clr = (wr_en_i && wr_slot_i == RS_FLAG) ? wdata_i : '0;
   // a cleared bit stays clear for this edge; owned lines re-arm next edge
   assign flag_d = owned_i & ~clr & (flag_q | hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q  <= '0;
         dir_q  <= '0;
         lvl_q  <= '0;
         mask_q <= '0;
         flag_q <= '0;
      end else begin
         flag_q <= flag_d;
         if (wr_en_i) begin
            unique case (wr_slot_i)
               RS_OUT:  out_q  <= wdata_i;
               RS_DIR:  dir_q  <= wdata_i;
               RS_LVL:  lvl_q  <= wdata_i;
               RS_MASK: mask_q <= wdata_i;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      unique case (rd_slot_i)
         RS_OUT:  rdata_o = out_q;
         RS_DIR:  rdata_o = dir_q;
         RS_IN:   rdata_o = sync_i;
         RS_LVL:  rdata_o = lvl_q;
         RS_FLAG: rdata_o = flag_q;
         RS_MASK: rdata_o = mask_q;
         RS_MIR:  rdata_o = sync_i;
         default: rdata_o = '0;
      endcase
   end

   assign out_o = out_q;
   assign dir_o = dir_q;
   assign irq_o = |(flag_q & mask_q);

   // R6
   foreign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flag_q & ~$past(owned_i)) == '0));

   // R7
   w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_slot_i == RS_FLAG) |=> ((flag_q & $past(wdata_i)) == '0));

   // R8
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq_o);

endmodule

// File: rtl/gpio_dual_bank.sv
module gpio_dual_bank
   import gpio_pkg::*;
#(
   parameter int unsigned LINES       = 32,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              perm_i,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wen,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [LINES-1:0]  pin_in,
   output logic [LINES-1:0]  pin_out,
   output logic [LINES-1:0]  pin_oe,
   output logic              irq_open,
   output logic              irq_prot
);

   localparam int unsigned IDX_W   = ADDR_W - 2;
   localparam int unsigned IDX_EN  = 7;
   localparam int unsigned IDX_OWN = 15;

   if (LINES < 1 || LINES > BUS_W) begin : g_bad_lines
      $error("gpio_dual_bank: LINES must be 1..32");
   end
   if (ADDR_W != 6) begin : g_bad_addr
      $error("gpio_dual_bank: ADDR_W must be 6");
   end

   logic [IDX_W-1:0] idx;
   logic             prot_area, open_area, bank_area;
   logic [BUS_W-1:0] wreg;
   logic [LINES-1:0] wlines;
   reg_slot_e        slot;
   logic [LINES-1:0] sync_in;
   logic [LINES-1:0] owner_q, enable_q;
   logic [LINES-1:0] o_rd, o_out, o_dir, p_rd, p_out, p_dir;
   logic [LINES-1:0] rd_lines;
   logic             open_we, prot_we;

   assign idx       = bus_addr[ADDR_W-1:2];
   assign open_area = (idx < IDX_W'(IDX_EN));
   assign prot_area = !open_area;
   assign bank_area = (idx != IDX_W'(IDX_EN)) && (idx != IDX_W'(IDX_OWN));
   assign slot      = reg_slot_e'(idx[2:0]);
   assign wreg      = lane_swap(bus_wdata);
   assign wlines    = wreg[LINES-1:0];
   assign open_we   = bus_wen && open_area;
   assign prot_we   = bus_wen && perm_i && prot_area && bank_area;

   gpio_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (pin_in),
      .sync_o  (sync_in)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owner_q  <= '0;
         enable_q <= '0;
      end else if (bus_wen && perm_i) begin
         if (idx == IDX_W'(IDX_OWN)) owner_q  <= wlines;
         if (idx == IDX_W'(IDX_EN))  enable_q <= wlines;
      end
   end

   gpio_bank #(.LINES(LINES)) u_open (
      .clk       (clk),
      .rst_n     (rst_n),
      .owned_i   (owner_q),
      .sync_i    (sync_in),
      .wr_en_i   (open_we),
      .wr_slot_i (slot),
      .wdata_i   (wlines),
      .rd_slot_i (slot),
      .rdata_o   (o_rd),
      .out_o     (o_out),
      .dir_o     (o_dir),
      .irq_o     (irq_open)
   );

   gpio_bank #(.LINES(LINES)) u_prot (
      .clk       (clk),
      .rst_n     (rst_n),
      .owned_i   (~owner_q),
      .sync_i    (sync_in),
      .wr_en_i   (prot_we),
      .wr_slot_i (slot),
      .wdata_i   (wlines),
      .rd_slot_i (slot),
      .rdata_o   (p_rd),
      .out_o     (p_out),
      .dir_o     (p_dir),
      .irq_o     (irq_prot)
   );

   for (genvar n = 0; n < LINES; n++) begin : g_pin
      assign pin_out[n] = owner_q[n] ? o_out[n] : p_out[n];
      assign pin_oe[n]  = owner_q[n] ? o_dir[n] : p_dir[n];
   end

   always_comb begin
      if (open_area)                     rd_lines = o_rd;
      else if (!perm_i)                  rd_lines = '0;
      else if (idx == IDX_W'(IDX_OWN))   rd_lines = owner_q;
      else if (idx == IDX_W'(IDX_EN))    rd_lines = enable_q;
      else                               rd_lines = p_rd;
   end

   assign bus_rdata = lane_swap(BUS_W'(rd_lines));

   // R4
   owner_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wen && !perm_i && idx == IDX_W'(IDX_OWN)) |=> $stable(owner_q));

   // R4
   prot_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!perm_i && prot_area) |-> (bus_rdata == '0));

endmodule

// File: tb/sim_gpio_dual_bank.sv
module sim_gpio_dual_bank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        perm = 1'b0;
   logic [5:0]  addr = '0;
   logic        wen = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out, pin_oe;
   logic        irq_open, irq_prot;
   int          total = 0;
   int          bad = 0;
   int          cycles = 0;
   logic        done = 1'b0;

   always #2.5 clk = ~clk;

   gpio_dual_bank u0 (
      .clk(clk), .rst_n(rst_n), .perm_i(perm), .bus_addr(addr), .bus_wen(wen),
      .bus_wdata(wdata), .bus_rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
      .pin_oe(pin_oe), .irq_open(irq_open), .irq_prot(irq_prot)
   );

   function automatic logic [31:0] sw(input logic [31:0] v);
      return {v[7:0], v[15:8], v[23:16], v[31:24]};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic p, input logic [5:0] a, input logic [31:0] v);
      @(negedge clk);
      perm = p; addr = a; wdata = sw(v); wen = 1'b1;
      @(negedge clk);
      wen = 1'b0;
   endtask

   task automatic bus_rd(input logic p, input logic [5:0] a, output logic [31:0] v);
      @(negedge clk);
      perm = p; addr = a; wen = 1'b0;
      #1 v = sw(rdata);
   endtask

   // {perm, write, addr, data, expected readback}
   localparam int NV = 12;
   localparam logic [71:0] VEC [NV] = '{
      {1'b1, 1'b1, 6'h3C, 32'h0000FFFF, 32'h0000FFFF},
      {1'b1, 1'b1, 6'h00, 32'hA5A5A5A5, 32'hA5A5A5A5},
      {1'b1, 1'b1, 6'h04, 32'h0F0F0F0F, 32'h0F0F0F0F},
      {1'b1, 1'b1, 6'h20, 32'h12345678, 32'h12345678},
      {1'b1, 1'b1, 6'h24, 32'hFFFF0000, 32'hFFFF0000},
      {1'b1, 1'b1, 6'h1C, 32'hDEADBEEF, 32'hDEADBEEF},
      {1'b0, 1'b1, 6'h20, 32'h00000000, 32'h00000000},
      {1'b0, 1'b1, 6'h3C, 32'hFFFFFFFF, 32'h00000000},
      {1'b0, 1'b1, 6'h00, 32'h5A5A5A5A, 32'h5A5A5A5A},
      {1'b1, 1'b0, 6'h20, 32'h00000000, 32'h12345678},
      {1'b1, 1'b0, 6'h3C, 32'h00000000, 32'h0000FFFF},
      {1'b1, 1'b0, 6'h1C, 32'h00000000, 32'hDEADBEEF}
   };

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cycles);
         finish_up();
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 pin_oe", pin_oe, 32'h0);
      chk("R1 pin_out", pin_out, 32'h0);
      chk("R1 irqs", {30'b0, irq_open, irq_prot}, 32'h0);
      bus_rd(1'b1, 6'h3C, v); chk("R1 owner", v, 32'h0);
      bus_rd(1'b1, 6'h14, v); chk("R1 mask", v, 32'h0);

      // R4 R9 R3 table walk
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][70]) bus_wr(VEC[i][71], VEC[i][69:64], VEC[i][63:32]);
         bus_rd(VEC[i][71], VEC[i][69:64], v);
         chk($sformatf("R4 vector %0d", i), v, VEC[i][31:0]);
      end
      // R3 R9 mixed ownership
      chk("R3 pin_out", pin_out, 32'h12345A5A);
      chk("R9 pin_oe", pin_oe, 32'hFFFF0F0F);

      // R6: pins low, both levels active-low
      repeat (4) @(negedge clk);
      bus_rd(1'b1, 6'h10, v); chk("R6 open flags", v, 32'h0000FFFF);
      bus_rd(1'b1, 6'h30, v); chk("R6 prot flags", v, 32'hFFFF0000);
      chk("R8 unmasked quiet", {31'b0, irq_open}, 32'h0);
      bus_wr(1'b1, 6'h14, 32'h00000001);
      chk("R8 irq_open", {31'b0, irq_open}, 32'h1);

      // R7 clear with level inactive
      bus_wr(1'b1, 6'h0C, 32'hFFFFFFFF);
      bus_wr(1'b1, 6'h10, 32'h0000FFFF);
      repeat (2) @(negedge clk);
      bus_rd(1'b1, 6'h10, v); chk("R7 cleared", v, 32'h0);
      chk("R8 irq_open low", {31'b0, irq_open}, 32'h0);
      bus_wr(1'b1, 6'h30, 32'h00000000);
      bus_rd(1'b1, 6'h30, v); chk("R7 zero write", v, 32'hFFFF0000);

      // R7 re-arm while level persists
      @(negedge clk);
      perm = 1'b1; addr = 6'h30; wdata = sw(32'h00010000); wen = 1'b1;
      @(posedge clk); #1 wen = 1'b0;
      chk("R7 clear edge", sw(rdata), 32'hFFFE0000);
      @(posedge clk); #1;
      chk("R7 re-set", sw(rdata), 32'hFFFF0000);

      // R8 protected irq
      bus_wr(1'b1, 6'h34, 32'h00010000);
      chk("R8 irq_prot", {31'b0, irq_prot}, 32'h1);

      // R5 sync latency
      @(negedge clk);
      pin_in = 32'hCAFE0001; addr = 6'h08; perm = 1'b1;
      @(posedge clk); #1 chk("R5 one edge", sw(rdata), 32'h0);
      @(posedge clk); #1 chk("R5 two edges", sw(rdata), 32'hCAFE0001);
      bus_rd(1'b1, 6'h38, v); chk("R5 mirror", v, 32'hCAFE0001);
      bus_rd(1'b0, 6'h28, v); chk("R4 gated IN", v, 32'h0);

      // R2 raw lanes
      bus_wr(1'b1, 6'h3C, 32'hFFFFFFFF);
      @(negedge clk); perm = 1'b1; addr = 6'h00; wdata = 32'h000000FF; wen = 1'b1;
      @(negedge clk); wen = 1'b0;
      chk("R2 pin lanes", pin_out, 32'hFF000000);
      #1 chk("R2 raw read", rdata, 32'h000000FF);

      finish_up();
   end

endmodule